// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address, or into a fault code. It tries the paths in a fixed order. First, a privileged-code fetch, marked by the low address bit, passes straight through. Second, a physical-mode request is used as is. Third, an address that is not canonical is refused. Fourth, a kernel-only superpage window maps addresses directly. Last, the address goes to an external translation buffer, and the entry's execute-enable bit for the current privilege mode decides whether the fetch may proceed.

The translation buffer is not part of the block. The block drives a lookup request on one port (valid, virtual page number and address-space number), and the buffer returns its answer on the same port in the same cycle (hit, page frame and four execute-enable bits). Each accepted request produces one registered response in the next cycle. The response carries the physical address, an uncacheable flag and a two-bit fault code.

On an access violation or a miss, the block captures the faulting fetch address in a tag register. In the same cycle it writes a formatted page-table-entry address into a second register, built from a page-table base and the virtual page number scaled by eight.

Top module: `ifetch_xlate`

## Requirements
- R1: A request with `reqValid` high gives `respValid` high on the next rising edge, and no request gives `respValid` low. Reset clears every output register and both capture registers.
- R2: When `reqVa[0]` is 1, the response is `reqVa[43:0]` with bits 1:0 cleared, fault code 0 (none) and uncacheable 0. `luValid` stays low, and this holds whatever `reqPhys`, `spEnable` and `curMode` are.
- R3: With `reqPhys` high (and `reqVa[0]` low), the physical address equals the virtual address. If any of `reqVa[63:44]` is set, the fault code is 3 (machine check) instead.
- R4: When `reqVa[63:42]` are not all equal (non-canonical), a non-physical request faults with code 1 (access violation) and no lookup is made.
- R5: When `spEnable[1]` is 1 and `reqVa[42:41]` is 2, the superpage window applies with no lookup. It succeeds only when `curMode` is 0 (kernel); in any other mode it faults with code 1.
- R6: For a superpage hit, if `reqVa[39]` or `reqVa[40]` is set, the address is `reqVa[43:0]` with bits 43:40 forced to 1. Otherwise it is `reqVa[39:0]` with bits 43:40 cleared.
- R7: Every other canonical request raises `luValid`, with `luVpn = reqVa[42:13]` and `luAsn = curAsn`. When `luHit` is low, it faults with code 2 (miss).
- R8: On a lookup hit, the address is `{luPfn, reqVa[12:2], 2'b00}` if `luExecEn[curMode]` is 1. Otherwise it faults with code 1.
- R9: On any non-privileged response with fault code 0, `respUncached` equals physical bit 39 OR bit 40.
- R10: On fault code 1 or 2, `faultTag` takes `reqVa` and `faultForm` takes `ptBase | (reqVa[42:13] << 3)`. Neither register changes on any other response or when idle.
- R11: On any nonzero fault code, `respPa` is 0 and `respUncached` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request this cycle |
| reqVa | input | 64 | Fetch virtual address |
| reqPhys | input | 1 | Physical-mode request, skips translation |
| curMode | input | 2 | Current privilege mode, 0 = kernel |
| spEnable | input | 2 | Superpage enable field; bit 1 opens the window |
| curAsn | input | 8 | Current address-space number |
| ptBase | input | 64 | Page-table base for the formatted fault address |
| luValid | output | 1 | Lookup request to the translation buffer |
| luVpn | output | 30 | Virtual page number looked up |
| luAsn | output | 8 | Address-space number looked up |
| luHit | input | 1 | Buffer holds a matching entry |
| luPfn | input | 31 | Page frame of the matching entry |
| luExecEn | input | 4 | Execute enable, one bit per mode |
| respValid | output | 1 | Response valid |
| respPa | output | 44 | Physical address |
| respUncached | output | 1 | Access is uncacheable |
| respFault | output | 2 | 0 none, 1 access violation, 2 miss, 3 machine check |
| faultTag | output | 64 | Captured faulting fetch address |
| faultForm | output | 64 | Captured formatted page-table-entry address |

## Verification
The assertions check on every cycle that responses follow requests by exactly one edge, that privileged-code fetches never reach the lookup port and never fault, and that a faulting response carries a zero address. They also check that the capture registers take the fetch address on access violations and misses and hold their value at all other times, and that machine checks arise only from physical-mode requests. The address arithmetic itself can only be shown by the bench's scenarios. This covers superpage sign extension on bits 39 and 40, frame and offset assembly, mode-indexed execute enables, the formatted fault address, and the priority order when several path conditions hold at once.

// File: rtl/ifetch_xlate_pkg.sv
package ifetch_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_MISS = 2'd2,
    FLT_MCHK = 2'd3
  } fault_e;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  // Strobes from control to datapath for one request
  typedef struct packed {
    logic   respond;
    logic   capture;
    logic   selPal;
    logic   selPhys;
    logic   selSuper;
    logic   selTable;
    fault_e code;
  } strobe_t;

endpackage

// File: rtl/ifetch_xlate_ctrl.sv
module ifetch_xlate_ctrl
  import ifetch_xlate_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic                  reqValid,
  input  logic                  reqPhys,
  input  logic [MODE_W-1:0]     curMode,
  input  logic                  vaPal,
  input  logic                  vaCanon,
  input  logic                  inSuperWin,
  input  logic                  physBad,
  input  logic                  luHit,
  input  logic [(1<<MODE_W)-1:0] luExecEn,
  output logic                  luValid,
  output strobe_t               st
);

  always_comb begin
    st      = '0;
    st.code = FLT_NONE;
    luValid = 1'b0;
    if (reqValid) begin
      st.respond = 1'b1;
      if (vaPal) begin
        st.selPal = 1'b1;
      end else if (reqPhys) begin
        if (physBad) st.code = FLT_MCHK;
        else         st.selPhys = 1'b1;
      end else if (!vaCanon) begin
        st.code    = FLT_ACV;
        st.capture = 1'b1;
      end else if (inSuperWin) begin
        if (curMode == MODE_W'(MODE_KERNEL)) begin
          st.selSuper = 1'b1;
        end else begin
          st.code    = FLT_ACV;
          st.capture = 1'b1;
        end
      end else begin
        luValid = 1'b1;
        if (!luHit) begin
          st.code    = FLT_MISS;
          st.capture = 1'b1;
        end else if (!luExecEn[curMode]) begin
          st.code    = FLT_ACV;
          st.capture = 1'b1;
        end else begin
          st.selTable = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ifetch_xlate_dp.sv
module ifetch_xlate_dp
  import ifetch_xlate_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_IMPL_W  = 43,
  parameter int PA_IMPL_W  = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int UC_LO      = 39,
  parameter int UC_HI      = 40,
  parameter int PTE_SHIFT  = 3,
  localparam int VPN_W     = VA_IMPL_W - PAGE_SHIFT,
  localparam int PFN_W     = PA_IMPL_W - PAGE_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [VA_W-1:0]      reqVa,
  input  logic [1:0]           spEnable,
  input  logic [VA_W-1:0]      ptBase,
  input  logic [PFN_W-1:0]     luPfn,
  input  strobe_t              st,
  output logic                 vaPal,
  output logic                 vaCanon,
  output logic                 inSuperWin,
  output logic                 physBad,
  output logic [VPN_W-1:0]     vaVpn,
  output logic                 respValid,
  output logic [PA_IMPL_W-1:0] respPa,
  output logic                 respUncached,
  output fault_e               respFault,
  output logic [VA_W-1:0]      faultTag,
  output logic [VA_W-1:0]      faultForm
);

  localparam int HI_W = VA_W - VA_IMPL_W + 1;
  localparam logic [PA_IMPL_W-1:0] LOW_MASK =
    PA_IMPL_W'((64'd1 << UC_HI) - 64'd1);
  localparam logic [PA_IMPL_W-1:0] EXT_MASK = ~LOW_MASK;

  logic [HI_W-1:0]      vaHigh;
  logic [PA_IMPL_W-1:0] vaLow;
  logic [PA_IMPL_W-1:0] superPa;
  logic [PA_IMPL_W-1:0] tablePa;
  logic [PA_IMPL_W-1:0] paNext;
  logic                 ucNext;
  logic [VA_W-1:0]      formNext;

  assign vaPal      = reqVa[0];
  assign vaHigh     = reqVa[VA_W-1:VA_IMPL_W-1];
  assign vaCanon    = (&vaHigh) | ~(|vaHigh);
  assign inSuperWin = spEnable[1] && (reqVa[VA_IMPL_W-1:VA_IMPL_W-2] == 2'b10);
  assign vaVpn      = reqVa[VA_IMPL_W-1:PAGE_SHIFT];
  assign vaLow      = reqVa[PA_IMPL_W-1:0];

  generate
    if (VA_W > PA_IMPL_W) begin : g_wide
      assign physBad = |reqVa[VA_W-1:PA_IMPL_W];
    end else begin : g_narrow
      assign physBad = 1'b0;
    end
  endgenerate

  // Superpage: extend by the uncached bits, else trim to the low window
  always_comb begin
    if (vaLow[UC_LO] || vaLow[UC_HI]) superPa = vaLow | EXT_MASK;
    else                              superPa = vaLow & LOW_MASK;
  end

  assign tablePa = {luPfn, reqVa[PAGE_SHIFT-1:2], 2'b00};

  always_comb begin
    if (st.selPal)        paNext = {vaLow[PA_IMPL_W-1:2], 2'b00};
    else if (st.selPhys)  paNext = vaLow;
    else if (st.selSuper) paNext = superPa;
    else if (st.selTable) paNext = tablePa;
    else                  paNext = '0;
  end

  assign ucNext   = !st.selPal && (paNext[UC_LO] || paNext[UC_HI]);
  assign formNext = ptBase | (VA_W'(vaVpn) << PTE_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      respPa       <= '0;
      respUncached <= 1'b0;
      respFault    <= FLT_NONE;
    end else begin
      respValid <= st.respond;
      if (st.respond) begin
        respPa       <= paNext;
        respUncached <= ucNext;
        respFault    <= st.code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultTag  <= '0;
      faultForm <= '0;
    end else if (st.capture) begin
      faultTag  <= reqVa;
      faultForm <= formNext;
    end
  end

endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
  import ifetch_xlate_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_IMPL_W  = 43,
  parameter int PA_IMPL_W  = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int MODE_W     = 2,
  parameter int ASN_W      = 8,
  localparam int VPN_W     = VA_IMPL_W - PAGE_SHIFT,
  localparam int PFN_W     = PA_IMPL_W - PAGE_SHIFT,
  localparam int EN_W      = 1 << MODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VA_W-1:0]      reqVa,
  input  logic                 reqPhys,
  input  logic [MODE_W-1:0]    curMode,
  input  logic [1:0]           spEnable,
  input  logic [ASN_W-1:0]     curAsn,
  input  logic [VA_W-1:0]      ptBase,
  output logic                 luValid,
  output logic [VPN_W-1:0]     luVpn,
  output logic [ASN_W-1:0]     luAsn,
  input  logic                 luHit,
  input  logic [PFN_W-1:0]     luPfn,
  input  logic [EN_W-1:0]      luExecEn,
  output logic                 respValid,
  output logic [PA_IMPL_W-1:0] respPa,
  output logic                 respUncached,
  output logic [1:0]           respFault,
  output logic [VA_W-1:0]      faultTag,
  output logic [VA_W-1:0]      faultForm
);

  strobe_t st;
  fault_e  faultQ;
  logic    vaPal, vaCanon, inSuperWin, physBad;

  assign luAsn     = curAsn;
  assign respFault = faultQ;

  ifetch_xlate_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .reqValid   (reqValid),
    .reqPhys    (reqPhys),
    .curMode    (curMode),
    .vaPal      (vaPal),
    .vaCanon    (vaCanon),
    .inSuperWin (inSuperWin),
    .physBad    (physBad),
    .luHit      (luHit),
    .luExecEn   (luExecEn),
    .luValid    (luValid),
    .st         (st)
  );

  ifetch_xlate_dp #(
    .VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W), .PA_IMPL_W(PA_IMPL_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqVa        (reqVa),
    .spEnable     (spEnable),
    .ptBase       (ptBase),
    .luPfn        (luPfn),
    .st           (st),
    .vaPal        (vaPal),
    .vaCanon      (vaCanon),
    .inSuperWin   (inSuperWin),
    .physBad      (physBad),
    .vaVpn        (luVpn),
    .respValid    (respValid),
    .respPa       (respPa),
    .respUncached (respUncached),
    .respFault    (faultQ),
    .faultTag     (faultTag),
    .faultForm    (faultForm)
  );

endmodule

// File: rtl/ifetch_xlate_chk.sv
module ifetch_xlate_chk #(
  parameter int VA_W      = 64,
  parameter int PA_IMPL_W = 44
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [VA_W-1:0]      reqVa,
  input logic                 reqPhys,
  input logic                 luValid,
  input logic                 respValid,
  input logic [PA_IMPL_W-1:0] respPa,
  input logic                 respUncached,
  input logic [1:0]           respFault,
  input logic [VA_W-1:0]      faultTag,
  input logic [VA_W-1:0]      faultForm
);

  logic capResp;
  assign capResp = respValid && (respFault == 2'd1 || respFault == 2'd2);

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  a_r2_pal_clean: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVa[0]) |=> (respFault == 2'd0 && !respUncached && respPa[1:0] == 2'b00));
  a_r2_no_lookup: assert property (@(posedge clk) disable iff (!rstN)
    luValid |-> (reqValid && !reqVa[0] && !reqPhys));
  a_r3_mchk_phys_only: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault == 2'd3) |-> $past(reqPhys));
  a_r10_tag_capture: assert property (@(posedge clk) disable iff (!rstN)
    capResp |-> (faultTag == $past(reqVa)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !capResp |-> ($stable(faultTag) && $stable(faultForm)));
  a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault != 2'd0) |-> (respPa == '0 && !respUncached));

endmodule

bind ifetch_xlate ifetch_xlate_chk #(.VA_W(VA_W), .PA_IMPL_W(PA_IMPL_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqVa        (reqVa),
  .reqPhys      (reqPhys),
  .luValid      (luValid),
  .respValid    (respValid),
  .respPa       (respPa),
  .respUncached (respUncached),
  .respFault    (respFault),
  .faultTag     (faultTag),
  .faultForm    (faultForm)
);

// File: tb/ifetch_xlate_test.sv
`timescale 1ns/1ps
module ifetch_xlate_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [63:0] reqVa;
  logic        reqPhys;
  logic [1:0]  curMode;
  logic [1:0]  spEnable;
  logic [7:0]  curAsn;
  logic [63:0] ptBase;
  logic        luValid;
  logic [29:0] luVpn;
  logic [7:0]  luAsn;
  logic        luHit;
  logic [30:0] luPfn;
  logic [3:0]  luExecEn;
  logic        respValid;
  logic [43:0] respPa;
  logic        respUncached;
  logic [1:0]  respFault;
  logic [63:0] faultTag;
  logic [63:0] faultForm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] expTag  = '0;
  logic [63:0] expForm = '0;

  always #10 clk = ~clk;

  // Bench page table: derived from the page number
  function automatic logic tHit(input logic [29:0] v);
    return v[2:0] != 3'd7;
  endfunction
  function automatic logic [30:0] tPfn(input logic [29:0] v);
    return {v[29:0] ^ 30'h15A5A5A5, v[1]};
  endfunction
  function automatic logic [3:0] tEn(input logic [29:0] v);
    return v[6:3];
  endfunction

  assign luHit    = luValid && tHit(luVpn);
  assign luPfn    = tPfn(luVpn);
  assign luExecEn = tEn(luVpn);

  ifetch_xlate uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] va, input logic phys, input logic [1:0] sp,
                       input logic [1:0] mode, output logic [43:0] pa, output logic uc,
                       output logic [1:0] flt, output logic lu, output string tag);
    logic [29:0] vpn;
    logic [43:0] lo;
    logic [21:0] hi;
    vpn = va[42:13]; lo = va[43:0]; hi = va[63:42];
    pa = '0; uc = 0; flt = 0; lu = 0;
    if (va[0]) begin
      pa = {lo[43:2], 2'b00}; tag = "R2";
    end else if (phys) begin
      tag = "R3";
      if (va[63:44] != 0) flt = 3;
      else begin pa = lo; uc = lo[39] | lo[40]; end
    end else if (!(&hi) && (|hi)) begin
      flt = 1; tag = "R4";
    end else if (sp[1] && va[42:41] == 2'b10) begin
      tag = "R5";
      if (mode != 0) flt = 1;
      else begin
        tag = "R6";
        if (lo[39] | lo[40]) pa = lo | 44'hF00_0000_0000;
        else pa = {4'h0, lo[39:0]};
        uc = pa[39] | pa[40];
      end
    end else begin
      lu = 1;
      if (!tHit(vpn)) begin flt = 2; tag = "R7"; end
      else if (!tEn(vpn)[mode]) begin flt = 1; tag = "R8"; end
      else begin
        pa = {tPfn(vpn), va[12:2], 2'b00}; uc = pa[39] | pa[40]; tag = "R8";
      end
    end
    if (flt == 1 || flt == 2) begin
      expTag = va; expForm = ptBase | ({34'h0, vpn} << 3);
    end
  endtask

  // Drive at a falling edge, check the response at the next one
  task automatic apply(input logic [63:0] va, input logic phys, input logic [1:0] sp,
                       input logic [1:0] mode);
    logic [43:0] pa; logic uc; logic [1:0] flt; logic lu; string tag;
    reqValid = 1; reqVa = va; reqPhys = phys; spEnable = sp; curMode = mode;
    curAsn = 8'(va[20:13]);
    model(va, phys, sp, mode, pa, uc, flt, lu, tag);
    #1;
    chk(luValid == lu, "R7", "luValid", 64'(luValid), 64'(lu));
    if (lu) chk(luVpn == va[42:13] && luAsn == curAsn, "R7", "luVpn", 64'(luVpn), 64'(va[42:13]));
    @(negedge clk);
    chk(respValid == 1'b1, "R1", "respValid", 64'(respValid), 64'd1);
    chk(respFault == flt, tag, "respFault", 64'(respFault), 64'(flt));
    chk(respPa == pa, (flt != 0) ? "R11" : tag, "respPa", 64'(respPa), 64'(pa));
    chk(respUncached == uc, (flt != 0) ? "R11" : "R9", "respUncached", 64'(respUncached), 64'(uc));
    chk(faultTag == expTag, "R10", "faultTag", faultTag, expTag);
    chk(faultForm == expForm, "R10", "faultForm", faultForm, expForm);
  endtask

  task automatic idle();
    reqValid = 0; reqVa = 64'hFFFF_0000_DEAD_0000; reqPhys = 0;
    @(negedge clk);
    chk(respValid == 1'b0, "R1", "idle respValid", 64'(respValid), 64'd0);
    chk(faultTag == expTag && faultForm == expForm, "R10", "idle hold", faultTag, expTag);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; reqValid = 0; reqVa = '0; reqPhys = 0; curMode = 0; spEnable = 0;
    curAsn = 0; ptBase = 64'h0000_0200_0000_0000;
    repeat (3) @(negedge clk);
    chk(respValid == 0 && respPa == 0 && respFault == 0 && !respUncached, "R1", "reset outputs",
        64'(respPa), 64'd0);
    chk(faultTag == 0 && faultForm == 0, "R1", "reset capture", faultTag, 64'd0);
    rstN = 1;
    @(negedge clk);

    // Directed corners
    apply(64'hFFFF_F9AB_CDEF_1237, 1'b1, 2'b10, 2'd3);   // R2 privileged wins over phys
    apply(64'h0000_0080_1234_5678, 1'b1, 2'b00, 2'd1);   // R3 phys, uncached bit 39
    apply(64'h0001_0000_0000_0000, 1'b1, 2'b00, 2'd0);   // R3 machine check, no capture
    apply(64'h0100_0000_0000_2000, 1'b0, 2'b00, 2'd0);   // R4 non-canonical
    apply(64'hFFFF_FC80_0000_4000, 1'b0, 2'b10, 2'd0);   // R6 superpage, bit 39 extension
    apply(64'hFFFF_FC12_3456_7000, 1'b0, 2'b10, 2'd0);   // R6 superpage, trimmed
    apply(64'hFFFF_FC12_3456_7000, 1'b0, 2'b10, 2'd2);   // R5 non-kernel superpage
    apply(64'hFFFF_FC12_3456_7000, 1'b0, 2'b01, 2'd0);   // R7 window closed, lookup
    apply(64'h0000_0000_0000_E000, 1'b0, 2'b00, 2'd0);   // R7 miss (vpn low bits 7)
    idle();
    apply(64'h0000_0000_0001_A1FC, 1'b0, 2'b00, 2'd0);   // R8 lookup
    idle();

    for (int n = 0; n < 600; n++) begin
      logic [63:0] va; logic ph; int kind;
      kind = $urandom_range(0, 5);
      va = rnd64();
      ph = ($urandom_range(0, 3) == 0);
      case (kind)
        0: va[0] = 1'b1;
        1: begin ph = 1; if ($urandom_range(0, 1) == 1) va[63:44] = '0; va[0] = 0; end
        2: begin va[63:42] = '0; va[0] = 0; end
        3: begin va[63:42] = '1; va[0] = 0; end
        4: va[0] = 0;
        default: begin va[63:41] = {22'h3FFFFF, 1'b0}; va[0] = 0; end
      endcase
      if (n % 50 == 0) ptBase = rnd64() & 64'hFFFF_FFFF_FFFF_E000;
      apply(va, ph, 2'($urandom()), 2'($urandom()));
      if (n % 37 == 0) idle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule